// File: doc/BRIEF.md
# Computation sharing multiplier

This block multiplies two signed 17-bit operands without building a partial-product array. Each operand is in sign-magnitude form. The top bit is the sign, and the lower sixteen bits are the magnitude. A precomputer forms the eight odd multiples 1, 3, 5, 7, 9, 11, 13 and 15 of the magnitude of x. This bank is shared by every digit of the coefficient.

The coefficient magnitude is cut into four 4-bit digits. Each digit has its own select unit. A nonzero digit is rewritten as an odd value times 2^s, found by stripping its trailing zeros. The select unit then uses the odd value to pick one multiple from the bank, shifts that multiple left by s, and gates it to zero when the digit is 0000.

A merge stage weights the four digit contributions by their digit positions and adds them. It then applies the product sign, which is the XOR of the two operand signs, as a two's-complement negation. The 33-bit result is captured in a single output register whenever in_valid is high.

Top module: `csm_mult`

## Requirements
- R1: Each operand is sign-magnitude: bit 16 is the sign (1 = negative) and bits 15:0 are the magnitude.
- R2: One clock edge after in_valid is high, prod_out holds the product of the two operand values as a 33-bit two's-complement number.
- R3: out_valid equals the value of in_valid at the previous rising clock edge.
- R4: While in_valid is low, prod_out keeps its previous value whatever x_in and c_in do.
- R5: When either magnitude is zero, the captured product is 0 whatever the sign bits are, so no negative zero appears.
- R6: A coefficient whose magnitude is a power of two gives the correct product for every digit position and every shift within a digit.
- R7: A coefficient magnitude of 0xFFFF, where every digit selects the 15x multiple, gives the correct product.
- R8: A synchronous active-high rst clears prod_out to 0 and out_valid to 0 at the next rising edge.
- R9: With both magnitudes nonzero, bit 32 of the captured product is the XOR of the two sign bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture enable for the operands on this edge |
| x_in | input | 17 | Multiplicand, sign-magnitude |
| c_in | input | 17 | Coefficient, sign-magnitude |
| prod_out | output | 33 | Registered two's-complement product |
| out_valid | output | 1 | High one cycle after a capture |

## Verification
The hardest cases to reach from the ports are those that exercise every shift amount in every digit position. Random coefficients seldom produce a digit with two or three trailing zeros in the top digit while the other digits are zero. The stimulus therefore walks a single set bit through all sixteen coefficient positions, which gives each select unit every shift value in isolation. It also applies 0xFFFF, so that all four units pick the largest multiple at once. The sign-magnitude zero cases, with a zero magnitude and either sign set, are applied on purpose so that a negative zero would show up at the output.

// File: rtl/csm_pkg.sv
package csm_pkg;
    localparam int OPW    = 17;
    localparam int MAGW   = OPW - 1;
    localparam int DIGW   = 4;
    localparam int NDIG   = MAGW / DIGW;
    localparam int NALPHA = 1 << (DIGW - 1);
    localparam int SELW   = DIGW - 1;
    localparam int SHW    = $clog2(DIGW);
    localparam int ALPHW  = MAGW + DIGW;
    localparam int CONTW  = ALPHW + DIGW - 1;
    localparam int PMAGW  = 2 * MAGW;
    localparam int PRODW  = PMAGW + 1;

    typedef logic [MAGW-1:0]  mag_t;
    typedef logic [ALPHW-1:0] alpha_t;
    typedef logic [CONTW-1:0] contrib_t;
    typedef logic [DIGW-1:0]  digit_raw_t;

    typedef struct packed {
        logic            active;
        logic [SELW-1:0] sel;
        logic [SHW-1:0]  shift;
    } digit_t;

    function automatic digit_t decode_digit(input digit_raw_t nib);
        digit_t     d;
        digit_raw_t odd;
        int         tz;
        tz = 0;
        for (int i = DIGW - 1; i >= 0; i--) begin
            if (nib[i]) tz = i;
        end
        odd      = nib >> tz;
        d.active = |nib;
        d.shift  = SHW'(tz);
        d.sel    = odd[DIGW-1:1];
        return d;
    endfunction

    function automatic alpha_t odd_multiple(input mag_t m, input int k);
        alpha_t acc;
        int     odd;
        odd = 2 * k + 1;
        acc = '0;
        for (int b = 0; b < DIGW; b++) begin
            if (((odd >> b) & 1) == 1) acc = acc + (alpha_t'(m) << b);
        end
        return acc;
    endfunction
endpackage

// File: rtl/csm_precomp.sv
module csm_precomp
    import csm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  mag_t                    mag,
    output alpha_t [NALPHA-1:0]     alpha
);
    for (genvar k = 0; k < NALPHA; k++) begin : g_alpha
        assign alpha[k] = odd_multiple(mag, k);
        if (k > 0) begin : g_step
            // R2
            alpha_step_chk: assert property (@(posedge clk) disable iff (rst)
                alpha[k] == alpha[k-1] + (alpha_t'(mag) << 1));
        end else begin : g_base
            // R2
            alpha_base_chk: assert property (@(posedge clk) disable iff (rst)
                alpha[0] == alpha_t'(mag));
        end
    end
endmodule

// File: rtl/csm_select.sv
module csm_select
    import csm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  digit_raw_t          nib,
    input  alpha_t [NALPHA-1:0] alpha,
    output contrib_t            contrib
);
    digit_t   dec;
    alpha_t   picked;
    contrib_t shifted;

    always_comb begin
        dec     = decode_digit(nib);
        picked  = alpha[dec.sel];
        shifted = contrib_t'(picked) << dec.shift;
        contrib = shifted & {CONTW{dec.active}};
    end

    // R6
    digit_value_chk: assert property (@(posedge clk) disable iff (rst)
        contrib == contrib_t'(nib) * contrib_t'(alpha[0]));
endmodule

// File: rtl/csm_merge.sv
module csm_merge
    import csm_pkg::*;
(
    input  contrib_t [NDIG-1:0] contrib,
    input  logic                negate,
    output logic [PRODW-1:0]    prod
);
    logic [PMAGW-1:0] mag_sum;
    logic [PRODW-1:0] ext;

    always_comb begin
        mag_sum = '0;
        for (int i = 0; i < NDIG; i++) begin
            mag_sum = mag_sum + (PMAGW'(contrib[i]) << (DIGW * i));
        end
        ext  = {1'b0, mag_sum};
        prod = negate ? (~ext + PRODW'(1)) : ext;
    end
endmodule

// File: rtl/csm_mult.sv
module csm_mult
    import csm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OPW-1:0]   x_in,
    input  logic [OPW-1:0]   c_in,
    output logic [PRODW-1:0] prod_out,
    output logic             out_valid
);
    logic                x_neg, c_neg;
    mag_t                x_mag, c_mag;
    alpha_t [NALPHA-1:0] bank;
    contrib_t [NDIG-1:0] parts;
    logic [PRODW-1:0]    prod_next;

    assign x_neg = x_in[MAGW];
    assign c_neg = c_in[MAGW];
    assign x_mag = x_in[MAGW-1:0];
    assign c_mag = c_in[MAGW-1:0];

    csm_precomp u_pre (
        .clk   (clk),
        .rst   (rst),
        .mag   (x_mag),
        .alpha (bank)
    );

    for (genvar d = 0; d < NDIG; d++) begin : g_sel
        csm_select u_sel (
            .clk     (clk),
            .rst     (rst),
            .nib     (c_mag[d*DIGW +: DIGW]),
            .alpha   (bank),
            .contrib (parts[d])
        );
    end

    csm_merge u_merge (
        .contrib (parts),
        .negate  (x_neg ^ c_neg),
        .prod    (prod_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_out  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) prod_out <= prod_next;
        end
    end

    // R3
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R3
    valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(prod_out));
    // R5
    zero_mag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (x_mag == '0 || c_mag == '0)) |=> prod_out == '0);
    // R9
    sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && x_mag != '0 && c_mag != '0) |=> prod_out[PRODW-1] == $past(x_neg ^ c_neg));
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (prod_out == '0 && !out_valid));
endmodule

// File: tb/tb_csm_mult.sv
module tb_csm_mult;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [16:0] x_in = '0;
    logic [16:0] c_in = '0;
    logic [32:0] prod_out;
    logic        out_valid;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    csm_mult dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .x_in(x_in), .c_in(c_in),
        .prod_out(prod_out), .out_valid(out_valid)
    );

    function automatic logic [32:0] ref_prod(input logic [16:0] a, input logic [16:0] b);
        longint va, vb, p;
        va = a[16] ? -longint'(a[15:0]) : longint'(a[15:0]);
        vb = b[16] ? -longint'(b[15:0]) : longint'(b[15:0]);
        p  = va * vb;
        return p[32:0];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [16:0] a, input logic [16:0] b);
        @(negedge clk);
        x_in = a; c_in = b; in_valid = 1'b1;
        @(negedge clk);
        check(tag, 64'(prod_out), 64'(ref_prod(a, b)));
        check("R3 valid high", 64'(out_valid), 64'd1);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R8 reset prod", 64'(prod_out), 64'd0);
        check("R8 reset valid", 64'(out_valid), 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_random;
        for (int i = 0; i < 40; i++) begin
            apply("R2 random", 17'($urandom), 17'($urandom));
        end
    endtask

    task automatic t_signs;
        apply("R1 R9 pos*pos", 17'h0_1234, 17'h0_0ABC);
        apply("R1 R9 neg*pos", 17'h1_1234, 17'h0_0ABC);
        apply("R9 pos*neg", 17'h0_1234, 17'h1_0ABC);
        apply("R9 neg*neg", 17'h1_FFFF, 17'h1_FFFF);
        check("R9 sign bit", 64'(prod_out[32]), 64'd0);
    endtask

    task automatic t_zero;
        apply("R5 c zero", 17'h0_7777, 17'h0_0000);
        apply("R5 c neg zero", 17'h0_7777, 17'h1_0000);
        apply("R5 x neg zero", 17'h1_0000, 17'h0_5555);
        check("R5 no negative zero", 64'(prod_out), 64'd0);
    endtask

    task automatic t_all_ones;
        apply("R7 ones pos", 17'h0_ABCD, 17'h0_FFFF);
        apply("R7 ones neg", 17'h0_FFFF, 17'h1_FFFF);
        apply("R7 ones x1", 17'h0_0001, 17'h0_FFFF);
    endtask

    task automatic t_pow2;
        for (int b = 0; b < 16; b++) begin
            apply("R6 pow2", 17'h0_9E37, 17'(1 << b));
            apply("R6 pow2 neg", 17'h0_FFFF, 17'h1_0000 | 17'(1 << b));
        end
    endtask

    task automatic t_hold;
        logic [32:0] keep;
        apply("R4 setup", 17'h0_0F0F, 17'h1_3003);
        keep = prod_out;
        x_in = 17'h0_FFFF; c_in = 17'h0_FFFF;
        @(negedge clk);
        check("R3 valid low", 64'(out_valid), 64'd0);
        x_in = 17'h1_1111; c_in = 17'h0_2222;
        @(negedge clk);
        check("R4 hold", 64'(prod_out), 64'(keep));
    endtask

    task automatic t_reset_mid;
        apply("R8 before", 17'h0_4321, 17'h0_1234);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R8 mid prod", 64'(prod_out), 64'd0);
        check("R8 mid valid", 64'(out_valid), 64'd0);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        t_reset;
        t_signs;
        t_zero;
        t_all_ones;
        t_pow2;
        t_hold;
        t_random;
        t_reset_mid;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule